// File: doc/BRIEF.md
# Delay-Line Snapshot Fine-Time Encoder

This block turns one sampled picture of a tapped delay line into a calibrated fine-time word. Each snapshot is a wide vector in which bit 0 is the tap nearest the launch point and higher bits lie farther along the line. When the snapshot strobe is high, the snapshot is reduced to a tap count. That count then selects one entry of a writable lookup table, and the entry is presented as the fine-time result.

The reduction method is fixed at build time. Population-count mode counts the set taps. This is cheap, but a zero bubble inside the run of ones lowers the count. Trace mode reports the position of the farthest set tap, so a bubble does not shorten the result. The table holds one value per possible count. On reset it is loaded with the identity scale. Calibration logic or a host can then overwrite entries through a simple address/data/write-enable port, typically with count times the average per-tap delay.

The data path has two register stages: first the count, then the table lookup. The block contains no state machine.

Top module: `dlenc_top`

## Requirements
- R1: After reset, `fine_valid` is 0, `fine_time` is 0, and every table entry equals its own index.
- R2: In population-count mode (`MODE` = `RED_POPCOUNT`), the tap count is the number of ones in `snap_bits`, including any ones beyond a zero bubble.
- R3: In trace mode (`MODE` = `RED_TRACE`), the tap count is one plus the index of the highest set bit of `snap_bits`. An all-zero snapshot gives 0, and zero bubbles below the highest one do not change the result.
- R4: The reported `fine_time` is the table entry addressed by the tap count, not the raw count.
- R5: A cycle with `cal_we` high writes `cal_data` into entry `cal_addr` when `cal_addr` is at most `TAPS`. A write to a larger address changes no entry.
- R6: A strobe sampled at clock edge n makes `fine_valid` high for exactly the cycle after edge n+1, with `fine_time` updated at that same edge.
- R7: Without a strobe, `fine_valid` stays low and `fine_time` keeps its last value.
- R8: When a write and a lookup hit the same entry at the same edge, the lookup returns the value held before the write. Later lookups return the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snap_valid | input | 1 | Strobe marking `snap_bits` as a snapshot to convert |
| snap_bits | input | TAPS | Sampled delay-line taps; bit 0 is nearest the launch point |
| cal_we | input | 1 | Table write enable |
| cal_addr | input | CNT_W | Table entry to write (CNT_W = clog2(TAPS+1)) |
| cal_data | input | FT_W | Value to write into the table |
| fine_valid | output | 1 | Result strobe, two cycles after `snap_valid` |
| fine_time | output | FT_W | Calibrated fine-time value |

## Verification
A wrong count, such as a popcount/trace mix-up, a bubble handled wrongly or an off-by-one on the highest tap, shows up as a wrong `fine_time` on the very conversion that exposes it, two cycles after the strobe. A corrupted table entry stays hidden until a snapshot with that exact count is converted. For that reason, the table is rewritten at random, and counts are spread across the full range, including 0 and `TAPS`. An address that aliases a wide write into a lower entry, or a read-after-write ordering fault, only shows on a lookup of the affected entry, so directed cases pair each such write with an immediate lookup.

// File: rtl/dlenc_pkg.sv
package dlenc_pkg;
    typedef enum logic {
        RED_POPCOUNT = 1'b0,
        RED_TRACE    = 1'b1
    } red_mode_e;
endpackage

// File: rtl/dlenc_popcount.sv
module dlenc_popcount #(
    parameter int TAPS  = 600,
    parameter int CNT_W = 10
) (
    input  logic [TAPS-1:0]  bits_i,
    output logic [CNT_W-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < TAPS; i++) begin
            count_o = count_o + CNT_W'(bits_i[i]);
        end
    end
endmodule

// File: rtl/dlenc_trace.sv
module dlenc_trace #(
    parameter int TAPS  = 600,
    parameter int CNT_W = 10
) (
    input  logic [TAPS-1:0]  bits_i,
    output logic [CNT_W-1:0] count_o
);
    always_comb begin
        count_o = '0;
        for (int i = 0; i < TAPS; i++) begin
            if (bits_i[i]) begin
                count_o = CNT_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/dlenc_table.sv
module dlenc_table #(
    parameter int DEPTH = 601,
    parameter int AW    = 10,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] tbl [DEPTH];
    logic          wr_ok;

    assign wr_ok = we_i && (waddr_i <= AW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl[i] <= DW'(i);
            end
            rdata_o <= '0;
        end else begin
            if (wr_ok) begin
                tbl[waddr_i] <= wdata_i;
            end
            if (re_i) begin
                rdata_o <= tbl[raddr_i];
            end
        end
    end

    // R5: an accepted write lands in the addressed entry
    p_wr_lands_r5: assert property (@(posedge clk) disable iff (rst)
        wr_ok |=> tbl[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/dlenc_top.sv
module dlenc_top
    import dlenc_pkg::*;
#(
    parameter int        TAPS  = 600,
    parameter int        FT_W  = 16,
    parameter red_mode_e MODE  = RED_POPCOUNT,
    localparam int       CNT_W = $clog2(TAPS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snap_valid,
    input  logic [TAPS-1:0]  snap_bits,
    input  logic             cal_we,
    input  logic [CNT_W-1:0] cal_addr,
    input  logic [FT_W-1:0]  cal_data,
    output logic             fine_valid,
    output logic [FT_W-1:0]  fine_time
);
    localparam int DEPTH = TAPS + 1;

    logic [CNT_W-1:0] raw_cnt;
    logic [CNT_W-1:0] s1_cnt;
    logic             s1_v;

    generate
        if (MODE == RED_TRACE) begin : g_trace
            dlenc_trace #(.TAPS(TAPS), .CNT_W(CNT_W)) red_i (
                .bits_i (snap_bits),
                .count_o(raw_cnt)
            );
        end else begin : g_pop
            dlenc_popcount #(.TAPS(TAPS), .CNT_W(CNT_W)) red_i (
                .bits_i (snap_bits),
                .count_o(raw_cnt)
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v   <= 1'b0;
            s1_cnt <= '0;
            fine_valid <= 1'b0;
        end else begin
            s1_v <= snap_valid;
            if (snap_valid) begin
                s1_cnt <= raw_cnt;
            end
            fine_valid <= s1_v;
        end
    end

    dlenc_table #(.DEPTH(DEPTH), .AW(CNT_W), .DW(FT_W)) tbl_i (
        .clk    (clk),
        .rst    (rst),
        .we_i   (cal_we),
        .waddr_i(cal_addr),
        .wdata_i(cal_data),
        .re_i   (s1_v),
        .raddr_i(s1_cnt),
        .rdata_o(fine_time)
    );

    // R2 / R3: the registered count never exceeds the number of taps
    p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
        s1_v |-> s1_cnt <= CNT_W'(TAPS));
    // R6: a captured count produces a result on the next edge
    p_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
        s1_v |=> fine_valid);
    // R6: no result without a captured count one edge earlier
    p_valid_src_r6: assert property (@(posedge clk) disable iff (rst)
        fine_valid |-> $past(s1_v));
    // R7: the output word holds when no lookup is done
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !s1_v |=> $stable(fine_time));
endmodule

// File: tb/dlenc_top_tb.sv
module dlenc_top_tb_top;
    import dlenc_pkg::*;

    localparam int  TAPS    = 600;
    localparam int  FT_W    = 16;
    localparam int  CNT_W   = $clog2(TAPS + 1);
    localparam time CLK_PER = 10ns;

    logic             clk = 1'b0;
    logic             rst;
    logic             snap_valid;
    logic [TAPS-1:0]  snap_bits;
    logic             cal_we;
    logic [CNT_W-1:0] cal_addr;
    logic [FT_W-1:0]  cal_data;
    logic             pv, tv;
    logic [FT_W-1:0]  pt, tt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [FT_W-1:0] model [TAPS+1];

    always #(CLK_PER/2) clk = ~clk;

    dlenc_top #(.TAPS(TAPS), .FT_W(FT_W), .MODE(RED_POPCOUNT)) dut_i (
        .clk(clk), .rst(rst), .snap_valid(snap_valid), .snap_bits(snap_bits),
        .cal_we(cal_we), .cal_addr(cal_addr), .cal_data(cal_data),
        .fine_valid(pv), .fine_time(pt));

    dlenc_top #(.TAPS(TAPS), .FT_W(FT_W), .MODE(RED_TRACE)) dut_tr_i (
        .clk(clk), .rst(rst), .snap_valid(snap_valid), .snap_bits(snap_bits),
        .cal_we(cal_we), .cal_addr(cal_addr), .cal_data(cal_data),
        .fine_valid(tv), .fine_time(tt));

    function automatic int ones(input logic [TAPS-1:0] b);
        int n = 0;
        for (int i = 0; i < TAPS; i++) n += int'(b[i]);
        return n;
    endfunction

    function automatic int farthest(input logic [TAPS-1:0] b);
        int n = 0;
        for (int i = 0; i < TAPS; i++) if (b[i]) n = i + 1;
        return n;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cal_write(input int a, input logic [FT_W-1:0] d);
        @(negedge clk);
        cal_we = 1'b1; cal_addr = CNT_W'(a); cal_data = d;
        @(posedge clk);
        @(negedge clk);
        cal_we = 1'b0;
        if (a <= TAPS) model[a] = d;
    endtask

    // convert one snapshot; optionally write entry wa at the lookup edge
    task automatic convert(input logic [TAPS-1:0] b, input string tag,
                           input bit collide, input int wa, input logic [FT_W-1:0] wd);
        int ep, et;
        logic [FT_W-1:0] hp, ht;
        ep = ones(b);
        et = farthest(b);
        hp = model[ep];
        ht = model[et];
        @(negedge clk);
        snap_valid = 1'b1; snap_bits = b;
        @(posedge clk);
        @(negedge clk);
        snap_valid = 1'b0;
        chk({tag, " R6 no early valid"}, {31'd0, pv | tv}, 32'd0);
        if (collide) begin
            cal_we = 1'b1; cal_addr = CNT_W'(wa); cal_data = wd;
        end
        @(posedge clk);
        @(negedge clk);
        cal_we = 1'b0;
        if (collide && wa <= TAPS) model[wa] = wd;
        chk({tag, " R6 valid pop"}, {31'd0, pv}, 32'd1);
        chk({tag, " R6 valid trace"}, {31'd0, tv}, 32'd1);
        chk({tag, " R2 R4 popcount time"}, 32'(pt), 32'(hp));
        chk({tag, " R3 R4 trace time"}, 32'(tt), 32'(ht));
        @(posedge clk);
        @(negedge clk);
        chk({tag, " R7 valid drops"}, {31'd0, pv | tv}, 32'd0);
        chk({tag, " R7 pop holds"}, 32'(pt), 32'(hp));
        chk({tag, " R7 trace holds"}, 32'(tt), 32'(ht));
    endtask

    function automatic logic [TAPS-1:0] therm(input int n);
        logic [TAPS-1:0] b = '0;
        for (int i = 0; i < n; i++) b[i] = 1'b1;
        return b;
    endfunction

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [TAPS-1:0] b;
        void'($urandom(32'd4711));
        for (int i = 0; i <= TAPS; i++) model[i] = FT_W'(i);
        rst = 1'b1; snap_valid = 1'b0; snap_bits = '0;
        cal_we = 1'b0; cal_addr = '0; cal_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset valid", {30'd0, pv, tv}, 32'd0);
        chk("R1 reset time", {pt, tt}, 32'd0);
        // R1: identity table visible at boundaries
        convert('0, "zero", 1'b0, 0, '0);
        convert(therm(TAPS), "full", 1'b0, 0, '0);
        convert(therm(1), "one", 1'b0, 0, '0);
        // R2 / R3: bubble below the front
        b = therm(40); b[10] = 1'b0; b[11] = 1'b0;
        convert(b, "bubble", 1'b0, 0, '0);
        // R3: lone far tap
        b = '0; b[TAPS-1] = 1'b1;
        convert(b, "lonefar", 1'b0, 0, '0);
        // R4: table entry rather than raw count
        cal_write(25, 16'hA5A5);
        convert(therm(25), "r4_cal", 1'b0, 0, '0);
        // R5: out-of-range write must not alias into entry 488 or any other
        cal_write(1000, 16'hBEEF);
        convert(therm(1000 & 511), "r5_oob", 1'b0, 0, '0);
        convert(therm(1000 - 512), "r5_oob2", 1'b0, 0, '0);
        // R5: top entry writable
        cal_write(TAPS, 16'h7777);
        convert(therm(TAPS), "r5_top", 1'b0, 0, '0);
        // R8: write at the lookup edge returns old value, new value after
        convert(therm(5), "r8_same", 1'b1, 5, 16'h1234);
        convert(therm(5), "r8_after", 1'b0, 0, '0);
        // random mix
        for (int v = 0; v < 150; v++) begin
            int len, nb;
            if ($urandom_range(0, 3) == 0)
                cal_write(int'($urandom_range(0, TAPS)), FT_W'($urandom));
            len = int'($urandom_range(0, TAPS));
            b = therm(len);
            nb = int'($urandom_range(0, 4));
            for (int k = 0; k < nb; k++) begin
                if (len > 1) b[$urandom_range(0, len - 2)] = 1'b0;
            end
            convert(b, "rand", 1'b0, 0, '0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule